// File: doc/BRIEF.md
# UART Interrupt Cause Collector

This block collects the interrupt causes of a UART core and presents them, along with the modem and line status, in one 32-bit status word. The FIFOs and the serial engines sit outside. They supply the RX and TX fill counts, a pulse for each received character, the live line-status flags and the four modem input levels. The block turns these into five sticky cause bits. Several cause bits can be pending at the same time, so the host sees all of them in a single read. Each source has its own enable bit in a configuration word, and the interrupt output is raised while an enabled cause is pending.

The RX data-available cause is raised when the RX fill count reaches a power-of-two trigger level. The TX space-available cause is raised when the free space in the TX FIFO reaches its trigger level. The character-timeout cause is raised when received data has sat unread for a programmable number of bit-time units, and that period scales with the baud divisor. The host acknowledges causes by writing a byte to the status word. A 1 in that byte clears the matching cause, and clearing the modem cause also clears the modem change flags.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and right after its release, with zero RX count, zero line flags and low modem inputs, the status word is all zero and `irq` is low.
- R2: Status bits [31:24] carry RX count bits [7:0], and bits [7:6] carry RX count bits [9:8]. Bits [23:16] pass `line_flags` through unchanged. Bit 5 reads 0.
- R3: The cause vector sits in status bits [4:0]: bit0 line status, bit1 RX data available, bit2 character timeout, bit3 TX space available, bit4 modem status. Any combination of these bits can be pending at once.
- R4: When `stat_wr` is high, each cause bit whose `stat_wbyte` bit is 1 clears on that edge, and every other cause bit keeps its value. Status bits [7:6] are unaffected by the write. If a cause is set and cleared on the same edge, the set wins.
- R5: The enables are in the configuration word. Bit0 gates the RX causes (bits 1 and 2), bit1 gates TX space (bit 3), bit2 gates line status (bit 0) and bit3 gates modem status (bit 4). A source whose enable is low latches no cause. A source that is enabled while its condition already holds latches a cause on the next edge.
- R6: The RX trigger code is in configuration bits [22:20], and code n means 2^(n+2) bytes. Cause bit1 sets on the edge after the RX count rises to at least the threshold. It does not set again while the count stays at or above the threshold.
- R7: The TX trigger code is in configuration bits [18:16], with the same code-to-threshold mapping as R6. Cause bit3 sets on the edge after the free space (FIFO_DEPTH minus `tx_count`) rises to at least the threshold.
- R8: Cause bit0 sets on the edge after any of the line error flags (bits 1, 2, 3, 4 and 7 of `line_flags`) goes high from a state in which none was high.
- R9: Status bits [15:12] hold the sampled CTS, DSR, RI and DCD levels (`modem_in` bits 0..3). Status bits [11:8] are change flags in the same order. A change flag sets on either edge of its input whatever the enables, and all change flags clear when the host clears cause bit4. Inputs are compared against a reset value of 0.
- R10: Cause bit4 sets on the edge at which any modem input changes while the modem enable is high.
- R11: The RX data must be left unread for T = `tmo_val` × `baud_div` × 4 clocks while the RX enable is high and the RX count is nonzero. Cause bit2 then sets on the T-th edge after the last `rx_push` edge. It fires once per idle period, a new `rx_push` restarts the count, and a zero `tmo_val` or `baud_div` disables the timeout.
- R12: `irq` is high exactly when some pending cause bit has its enable high. Dropping an enable lowers `irq` without clearing the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word: enables [3:0], TX trigger code [18:16], RX trigger code [22:20] |
| tmo_val | input | TMO_W | Character timeout count in baud units |
| baud_div | input | BAUD_W | Baud divisor; one unit lasts 4 × baud_div clocks |
| rx_count | input | CNT_W | RX FIFO fill level |
| tx_count | input | CNT_W | TX FIFO fill level |
| rx_push | input | 1 | One-cycle pulse per character written into the RX FIFO |
| line_flags | input | 8 | Live line status flags from the serial engines |
| modem_in | input | 4 | Modem input levels: CTS, DSR, RI, DCD in bits 0..3 |
| stat_wr | input | 1 | Host byte write to the status word |
| stat_wbyte | input | 8 | Byte written; ones clear cause bits |
| stat_word | output | 32 | Packed status word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where two things happen on the same edge. One is a host clear that lands on the very edge a cause is set again. The bench reaches it by dropping the RX and TX enables for one step and then writing the clear on the edge where they come back on, so the enable-driven set and the clear collide. The other is the timeout's fire-once rule. The bench uses a small timeout and divisor so that the exact firing edge, a quiet interval of several periods and a restart by a fresh character all fit in a few hundred cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int CAUSE_W     = 5;
  localparam int CI_LINE     = 0;
  localparam int CI_RXDA     = 1;
  localparam int CI_CTO      = 2;
  localparam int CI_TXSP     = 3;
  localparam int CI_MDM      = 4;

  localparam int CFG_EN_RX   = 0;
  localparam int CFG_EN_TX   = 1;
  localparam int CFG_EN_LINE = 2;
  localparam int CFG_EN_MDM  = 3;
  localparam int CFG_TXL_LSB = 16;
  localparam int CFG_RXL_LSB = 20;

  localparam logic [7:0] LINE_ERR_MASK = 8'h9E;
  localparam int STAT_CNT_W  = 10;

  function automatic int lvl_thr(input logic [2:0] code);
    return 1 << (int'(code) + 2);
  endfunction
endpackage

// File: rtl/uart_irq_rise.sv
module uart_irq_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic en,
  output logic rise
);
  logic arm_d, arm_q;

  always_comb begin
    arm_d = cond & en;
    rise  = arm_d & ~arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/uart_irq_levels.sv
module uart_irq_levels
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 1024,
  localparam int CNT_W      = $clog2(FIFO_DEPTH)
) (
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [2:0]       rx_code,
  input  logic [2:0]       tx_code,
  output logic             rx_hit,
  output logic             tx_hit
);
  localparam int CW = CNT_W + 2;
  logic [CW-1:0] rx_thr, tx_thr, tx_free;

  always_comb begin
    rx_thr  = CW'(lvl_thr(rx_code));
    tx_thr  = CW'(lvl_thr(tx_code));
    tx_free = CW'(FIFO_DEPTH) - CW'(tx_count);
    rx_hit  = CW'(rx_count) >= rx_thr;
    tx_hit  = tx_free >= tx_thr;
  end
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lines,
  input  logic       clr,
  output logic [3:0] lvl_q,
  output logic [3:0] delta_q,
  output logic       any_edge
);
  logic [3:0] edges, delta_d;

  always_comb begin
    edges    = lines ^ lvl_q;
    any_edge = |edges;
    delta_d  = (delta_q & ~{4{clr}}) | edges;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lines;
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int TMO_W  = 16,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic [TMO_W-1:0]  tmo_val,
  input  logic [BAUD_W-1:0] baud_div,
  output logic              fire
);
  localparam int PW = BAUD_W + 2;

  logic [PW-1:0]    pre_q, pre_d, pre_last;
  logic [TMO_W-1:0] tk_q, tk_d, tk_last;
  logic             fired_q, fired_d;
  logic             cnt_en;

  always_comb begin
    pre_last = {baud_div, 2'b00} - PW'(1);
    tk_last  = tmo_val - TMO_W'(1);
    pre_d    = pre_q;
    tk_d     = tk_q;
    fired_d  = fired_q;
    fire     = 1'b0;
    cnt_en   = 1'b0;
    if (!active || restart) begin
      pre_d   = '0;
      tk_d    = '0;
      fired_d = 1'b0;
      cnt_en  = 1'b1;
    end else if (!fired_q) begin
      cnt_en = 1'b1;
      if (pre_q == pre_last) begin
        pre_d = '0;
        if (tk_q == tk_last) begin
          fire    = 1'b1;
          fired_d = 1'b1;
          tk_d    = '0;
        end else begin
          tk_d = tk_q + TMO_W'(1);
        end
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      tk_q    <= '0;
      fired_q <= 1'b0;
    end else if (cnt_en) begin
      pre_q   <= pre_d;
      tk_q    <= tk_d;
      fired_q <= fired_d;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 1024,
  parameter  int TMO_W      = 16,
  parameter  int BAUD_W     = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic [TMO_W-1:0]  tmo_val,
  input  logic [BAUD_W-1:0] baud_div,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_push,
  input  logic [7:0]        line_flags,
  input  logic [3:0]        modem_in,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wbyte,
  output logic [31:0]       stat_word,
  output logic              irq
);
  localparam int NEDGE = 3;

  logic en_rx, en_tx, en_line, en_mdm;
  logic rx_hit, tx_hit, line_err;
  logic [NEDGE-1:0] edge_cond, edge_en, edge_rise;
  logic tmo_active, tmo_fire;
  logic [3:0] mdm_lvl, mdm_delta;
  logic mdm_edge, mdm_clr;
  logic [CAUSE_W-1:0] cause_q, cause_d, set_v, clr_v, en_map;
  logic [STAT_CNT_W-1:0] rxc_s;
  logic unused_cfg;

  assign en_rx   = cfg_word[CFG_EN_RX];
  assign en_tx   = cfg_word[CFG_EN_TX];
  assign en_line = cfg_word[CFG_EN_LINE];
  assign en_mdm  = cfg_word[CFG_EN_MDM];
  assign unused_cfg = ^{cfg_word[31:23], cfg_word[19], cfg_word[15:4], stat_wbyte[7:5]};

  uart_irq_levels #(.FIFO_DEPTH(FIFO_DEPTH)) u_levels (
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_code  (cfg_word[CFG_RXL_LSB +: 3]),
    .tx_code  (cfg_word[CFG_TXL_LSB +: 3]),
    .rx_hit   (rx_hit),
    .tx_hit   (tx_hit)
  );

  assign line_err  = |(line_flags & LINE_ERR_MASK);
  assign edge_cond = {tx_hit, rx_hit, line_err};
  assign edge_en   = {en_tx, en_rx, en_line};

  for (genvar g = 0; g < NEDGE; g++) begin : g_rise
    uart_irq_rise u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (edge_cond[g]),
      .en   (edge_en[g]),
      .rise (edge_rise[g])
    );
  end

  assign tmo_active = en_rx && (rx_count != '0) && (tmo_val != '0) && (baud_div != '0);

  uart_irq_tmo #(.TMO_W(TMO_W), .BAUD_W(BAUD_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (tmo_active),
    .restart (rx_push),
    .tmo_val (tmo_val),
    .baud_div(baud_div),
    .fire    (tmo_fire)
  );

  assign mdm_clr = stat_wr & stat_wbyte[CI_MDM];

  uart_irq_modem u_modem (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (modem_in),
    .clr     (mdm_clr),
    .lvl_q   (mdm_lvl),
    .delta_q (mdm_delta),
    .any_edge(mdm_edge)
  );

  always_comb begin
    set_v          = '0;
    set_v[CI_LINE] = edge_rise[0];
    set_v[CI_RXDA] = edge_rise[1];
    set_v[CI_TXSP] = edge_rise[2];
    set_v[CI_CTO]  = tmo_fire;
    set_v[CI_MDM]  = mdm_edge & en_mdm;
    clr_v          = stat_wr ? stat_wbyte[CAUSE_W-1:0] : '0;
    cause_d        = (cause_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  always_comb begin
    en_map          = '0;
    en_map[CI_LINE] = en_line;
    en_map[CI_RXDA] = en_rx;
    en_map[CI_CTO]  = en_rx;
    en_map[CI_TXSP] = en_tx;
    en_map[CI_MDM]  = en_mdm;
    irq             = |(cause_q & en_map);
    rxc_s           = STAT_CNT_W'(rx_count);
    stat_word       = {rxc_s[7:0], line_flags, mdm_lvl, mdm_delta,
                       rxc_s[9:8], 1'b0, cause_q};
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 1024,
  localparam int CNT_W      = $clog2(FIFO_DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cfg_word,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             stat_wr,
  input logic [7:0]       stat_wbyte,
  input logic [31:0]      stat_word,
  input logic             irq
);
  // R4: a pending cause only drops on an edge where the host wrote a 1 for it
  a_r4_clear_only_by_host: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_word[4:0]) & ~stat_word[4:0] &
     ~({5{$past(stat_wr)}} & $past(stat_wbyte[4:0]))) == 5'd0);

  // R6: RX data-available rises only when the count met the threshold
  a_r6_rx_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[CI_RXDA]) |->
      (int'($past(rx_count)) >= lvl_thr($past(cfg_word[CFG_RXL_LSB +: 3]))));

  // R7: TX space rises only when free space met the threshold
  a_r7_tx_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[CI_TXSP]) |->
      ((FIFO_DEPTH - int'($past(tx_count))) >= lvl_thr($past(cfg_word[CFG_TXL_LSB +: 3]))));

  // R5: modem cause latches only while its enable was high
  a_r5_modem_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[CI_MDM]) |-> $past(cfg_word[CFG_EN_MDM]));

  // R11: timeout needs the RX enable and unread data
  a_r11_timeout_context: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[CI_CTO]) |-> ($past(cfg_word[CFG_EN_RX]) && ($past(rx_count) != '0)));

  // R9: a new change flag comes with a change in the sampled levels
  a_r9_delta_has_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_word[11:8] & ~$past(stat_word[11:8]))) |->
      (stat_word[15:12] != $past(stat_word[15:12])));

  // R12: no pending cause means no interrupt
  a_r12_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[4:0] == 5'd0) |-> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_word  (cfg_word),
  .rx_count  (rx_count),
  .tx_count  (tx_count),
  .stat_wr   (stat_wr),
  .stat_wbyte(stat_wbyte),
  .stat_word (stat_word),
  .irq       (irq)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
  localparam int DEPTH = 1024;
  localparam int NV    = 17;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic [15:0] tmo_val;
  logic [15:0] baud_div;
  logic [9:0]  rx_count;
  logic [9:0]  tx_count;
  logic        rx_push;
  logic [7:0]  line_flags;
  logic [3:0]  modem_in;
  logic        stat_wr;
  logic [7:0]  stat_wbyte;
  logic [31:0] stat_word;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .tmo_val(tmo_val),
    .baud_div(baud_div), .rx_count(rx_count), .tx_count(tx_count),
    .rx_push(rx_push), .line_flags(line_flags), .modem_in(modem_in),
    .stat_wr(stat_wr), .stat_wbyte(stat_wbyte), .stat_word(stat_word), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // en, rx_count, tx_count, line_flags, modem_in, wr, wbyte | cause, irq
  localparam logic [50:0] TV [0:NV-1] = '{
    {4'h0, 10'd0,   10'd1000, 8'h00, 4'h0, 1'b0, 8'h00, 5'h00, 1'b0},
    {4'hF, 10'd0,   10'd1000, 8'h00, 4'h0, 1'b0, 8'h00, 5'h00, 1'b0},
    {4'hF, 10'd300, 10'd1000, 8'h00, 4'h0, 1'b0, 8'h00, 5'h02, 1'b1},
    {4'hF, 10'd300, 10'd1000, 8'h00, 4'h0, 1'b1, 8'h02, 5'h00, 1'b0},
    {4'hF, 10'd100, 10'd1000, 8'h00, 4'h0, 1'b0, 8'h00, 5'h00, 1'b0},
    {4'hF, 10'd256, 10'd1000, 8'h00, 4'h0, 1'b0, 8'h00, 5'h02, 1'b1},
    {4'hF, 10'd256, 10'd896,  8'h00, 4'h0, 1'b0, 8'h00, 5'h0A, 1'b1},
    {4'hF, 10'd256, 10'd896,  8'h04, 4'h0, 1'b0, 8'h00, 5'h0B, 1'b1},
    {4'hF, 10'd256, 10'd896,  8'h04, 4'h1, 1'b0, 8'h00, 5'h1B, 1'b1},
    {4'hF, 10'd256, 10'd896,  8'h04, 4'h1, 1'b1, 8'hFF, 5'h00, 1'b0},
    {4'hF, 10'd255, 10'd897,  8'h20, 4'h1, 1'b0, 8'h00, 5'h00, 1'b0},
    {4'h0, 10'd300, 10'd0,    8'h02, 4'h0, 1'b0, 8'h00, 5'h00, 1'b0},
    {4'hF, 10'd300, 10'd0,    8'h02, 4'h0, 1'b0, 8'h00, 5'h0B, 1'b1},
    {4'hF, 10'd300, 10'd0,    8'h02, 4'h0, 1'b1, 8'h01, 5'h0A, 1'b1},
    {4'h4, 10'd300, 10'd0,    8'h02, 4'h0, 1'b0, 8'h00, 5'h0A, 1'b0},
    {4'hF, 10'd300, 10'd0,    8'h02, 4'h0, 1'b1, 8'h0A, 5'h0A, 1'b1},
    {4'hF, 10'd300, 10'd0,    8'h02, 4'h0, 1'b1, 8'h1F, 5'h00, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1:    return "R5 idle with enables";
      2, 4, 5: return "R6 rx trigger crossing";
      3:       return "R4 clear while level held";
      6:       return "R7 tx space at threshold";
      7:       return "R8 line error rise";
      8:       return "R10 modem edge";
      9, 16:   return "R4 clear all pending";
      10:      return "R8 non-error flag ignored";
      11:      return "R5 disabled sources latch nothing";
      12:      return "R3 several causes pending";
      13:      return "R4 partial clear";
      14:      return "R12 enable drop masks irq";
      default: return "R4 set wins over clear";
    endcase
  endfunction

  function automatic logic [31:0] mkcfg(input logic [3:0] en, input logic [2:0] rxl,
                                        input logic [2:0] txl);
    return (32'(rxl) << 20) | (32'(txl) << 16) | 32'(en);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_push();
    rx_push = 1'b1;
    step(1);
    rx_push = 1'b0;
  endtask

  task automatic host_clear(input logic [7:0] b);
    stat_wr = 1'b1; stat_wbyte = b;
    step(1);
    stat_wr = 1'b0; stat_wbyte = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0; cfg_word = mkcfg(4'h0, 3'd6, 3'd5);
    tmo_val = '0; baud_div = '0; rx_count = '0; tx_count = 10'd1000;
    rx_push = 1'b0; line_flags = '0; modem_in = '0; stat_wr = 1'b0; stat_wbyte = '0;
    step(3);
    chk("R1 status in reset", stat_word, 32'h0);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step(1);
    chk("R1 status after release", stat_word, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cfg_word   = mkcfg(TV[i][50:47], 3'd6, 3'd5);
      rx_count   = TV[i][46:37];
      tx_count   = TV[i][36:27];
      line_flags = TV[i][26:19];
      modem_in   = TV[i][18:15];
      stat_wr    = TV[i][14];
      stat_wbyte = TV[i][13:6];
      step(1);
      stat_wr = 1'b0; stat_wbyte = 8'h00;
      chk(row_tag(i), 32'(stat_word[4:0]), 32'(TV[i][5:1]));
      chk("R12 irq per table row", 32'(irq), 32'(TV[i][0]));
    end
    chk("R9 change flags cleared with modem cause", 32'(stat_word[15:8]), 32'h00);

    // R2 packing and R4 bits [7:6] untouched by a write
    cfg_word = mkcfg(4'h0, 3'd6, 3'd5);
    rx_count = 10'h2A5; line_flags = 8'h61; tx_count = 10'd1000;
    step(1);
    chk("R2 rx count low byte", 32'(stat_word[31:24]), 32'hA5);
    chk("R2 rx count high bits", 32'(stat_word[7:6]), 32'h2);
    chk("R2 line flags pass", 32'(stat_word[23:16]), 32'h61);
    chk("R2 bit5 zero", 32'(stat_word[5]), 32'h0);
    host_clear(8'hC0);
    chk("R4 bits 7:6 unaffected", 32'(stat_word[7:6]), 32'h2);

    // R9 / R10 modem byte
    rx_count = '0; line_flags = '0;
    cfg_word = mkcfg(4'h8, 3'd6, 3'd5);
    modem_in = 4'b0001; step(1);
    chk("R9 cts rise", 32'(stat_word[15:8]), 32'h11);
    chk("R10 modem cause set", 32'(stat_word[4]), 32'h1);
    modem_in = 4'b0101; step(1);
    chk("R9 ri rise", 32'(stat_word[15:8]), 32'h55);
    modem_in = 4'b0001; step(1);
    chk("R9 ri fall keeps flag", 32'(stat_word[15:8]), 32'h15);
    host_clear(8'h01);
    chk("R4 other clear keeps modem flags", 32'(stat_word[15:8]), 32'h15);
    chk("R4 modem cause kept", 32'(stat_word[4]), 32'h1);
    host_clear(8'h10);
    chk("R9 flags cleared by modem clear", 32'(stat_word[15:8]), 32'h10);
    cfg_word = mkcfg(4'h0, 3'd6, 3'd5);
    modem_in = 4'b0000; step(1);
    chk("R9 flag set while disabled", 32'(stat_word[15:8]), 32'h01);
    chk("R5 modem cause gated", 32'(stat_word[4]), 32'h0);
    host_clear(8'h10);

    // R11 timeout: T = 3*2*4 = 24
    cfg_word = mkcfg(4'h1, 3'd6, 3'd5);
    tmo_val = 16'd3; baud_div = 16'd2; rx_count = 10'd5;
    pulse_push();
    step(23);
    chk("R11 not yet at T-1", 32'(stat_word[2]), 32'h0);
    step(1);
    chk("R11 fires at T", 32'(stat_word[2]), 32'h1);
    chk("R12 irq from timeout", 32'(irq), 32'h1);
    host_clear(8'h04);
    step(60);
    chk("R11 fires once", 32'(stat_word[2]), 32'h0);
    pulse_push();
    step(20);
    pulse_push();
    step(23);
    chk("R11 restart by push", 32'(stat_word[2]), 32'h0);
    step(1);
    chk("R11 fires after restart", 32'(stat_word[2]), 32'h1);
    host_clear(8'h04);
    tmo_val = 16'd1; baud_div = 16'd5;
    pulse_push();
    step(19);
    chk("R11 scaled period early", 32'(stat_word[2]), 32'h0);
    step(1);
    chk("R11 scaled period fires", 32'(stat_word[2]), 32'h1);
    host_clear(8'h04);
    tmo_val = 16'd0;
    pulse_push();
    step(100);
    chk("R11 zero timeout disabled", 32'(stat_word[2]), 32'h0);

    // R6 / R7 other trigger codes
    cfg_word = mkcfg(4'h3, 3'd0, 3'd7);
    rx_count = 10'd3; tx_count = 10'd513;
    step(1);
    host_clear(8'h0A);
    chk("R6 code0 below 4", 32'(stat_word[1]), 32'h0);
    chk("R7 code7 free 511", 32'(stat_word[3]), 32'h0);
    rx_count = 10'd4; tx_count = 10'd512;
    step(1);
    chk("R6 code0 at 4", 32'(stat_word[1]), 32'h1);
    chk("R7 code7 free 512", 32'(stat_word[3]), 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule